// File: doc/BRIEF.md
# Manchester Line Transmitter with Preamble

This block turns bytes into a Manchester-coded serial line. A byte arrives on a valid/ready handshake. The transmitter then sends a frame made of four parts in order: an optional preamble, a start marker, the eight data bits with the least significant bit first, and finally a return to the idle level. Each bit lasts one bit period. A half-period tick, generated outside the block, splits each bit period into a first half and a second half. The line changes level at the boundary between the two halves.

The preamble has a selectable pattern and a length of 0 to 15 bit periods. Each preamble bit is coded exactly like a data bit. The coding polarity is selectable. The pattern, length and polarity are sampled when a byte is accepted and stay fixed until that frame ends. While no frame is in flight, the line follows the configured idle level.

Top module: `manch_tx`

## Requirements
- R1: While rst_ni is low, busy_o is 0, ready_o is 1 and line_o is 1.
- R2: A byte is accepted on a rising clock edge where valid_i and ready_o are both 1. busy_o is 1 from the next cycle on, and ready_o is 0 whenever busy_o is 1.
- R3: While busy_o is 0, line_o equals the value idle_lvl_i had in the previous cycle. half_tick_i causes no transitions while idle.
- R4: Each logic bit takes two halves. With pol_i=0, a 0 is sent as low then high and a 1 as high then low. With pol_i=1, a 0 is sent as high then low and a 1 as low then high.
- R5: During a frame, line_o changes only on a clock edge at which half_tick_i is 1. Each such edge outputs the next half.
- R6: Preamble pattern encoding on pat_sel_i: 0 gives all ones, 1 gives all zeros, 2 gives 0,1,0,1… and 3 gives 1,0,1,0…. Each alternating pattern starts with its first listed value.
- R7: pre_len_i=0 sends no preamble. A value of 1 to 15 sends exactly that many preamble bits.
- R8: After the preamble comes one start bit of logic 0, then data bits 0 through 7 in that order.
- R9: A frame with preamble length L takes 2*(L+9) half ticks. The next half tick after the last half clears busy_o and puts line_o back at the idle level.
- R10: Changes to pol_i, pat_sel_i and pre_len_i after a byte is accepted have no effect on the frame in flight.
- R11: valid_i asserted while busy_o is 1 is ignored. It neither alters the frame in flight nor starts another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_tick_i | input | 1 | One-cycle pulse marking each half-bit boundary |
| pol_i | input | 1 | Coding polarity |
| pat_sel_i | input | 2 | Preamble pattern select |
| pre_len_i | input | 4 | Preamble length in bit periods (0 disables the preamble) |
| idle_lvl_i | input | 1 | Line level while idle |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | Byte on data_i is valid |
| ready_o | output | 1 | A byte can be accepted |
| line_o | output | 1 | Encoded serial line |
| busy_o | output | 1 | A frame is in progress |

## Verification
The assertions check the following on every cycle:
- an accepted byte always raises busy_o;
- ready_o stays low during a frame;
- the line tracks the idle input whenever no frame runs;
- the line holds between half ticks during a frame;
- busy_o only falls on a tick.

Only the bench scenarios can show the actual half-level sequence of a frame. That covers the four preamble patterns, the zero and full preamble lengths, both polarities, the start bit and the data order. The scenarios also show the exact frame length, that configuration changes during a frame are ignored, and that a byte offered during a frame is dropped.

// File: rtl/manch_pkg.sv
package manch_pkg;
  localparam int LEN_W = 4;

  typedef enum logic [1:0] {
    PAT_ONES  = 2'd0,
    PAT_ZEROS = 2'd1,
    PAT_ZO    = 2'd2,
    PAT_OZ    = 2'd3
  } pat_e;

  typedef struct packed {
    logic             pol;
    pat_e             pat;
    logic [LEN_W-1:0] len;
  } frame_cfg_t;
endpackage

// File: rtl/manch_bit_sel.sv
module manch_bit_sel
  import manch_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  frame_cfg_t        cfg_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o
);
  logic [IDX_W-1:0] len_x;
  logic [IDX_W-1:0] data_off;
  logic             pre_bit;
  logic             data_bit;

  assign len_x    = IDX_W'(cfg_i.len);
  assign data_off = idx_i - len_x - IDX_W'(1);

  always_comb begin
    unique case (cfg_i.pat)
      PAT_ONES:  pre_bit = 1'b1;
      PAT_ZEROS: pre_bit = 1'b0;
      PAT_ZO:    pre_bit = idx_i[0];
      default:   pre_bit = ~idx_i[0];
    endcase
  end

  always_comb begin
    data_bit = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (data_off == IDX_W'(i)) data_bit = data_i[i];
  end

  // preamble, then start bit (0), then data
  always_comb begin
    if (idx_i < len_x)       bit_o = pre_bit;
    else if (idx_i == len_x) bit_o = 1'b0;
    else                     bit_o = data_bit;
  end
endmodule

// File: rtl/manch_enc.sv
module manch_enc (
  input  logic bit_i,
  input  logic pol_i,
  input  logic second_i,
  output logic lvl_o
);
  // first half level = bit ^ pol, second half is its complement
  assign lvl_o = bit_i ^ pol_i ^ second_i;
endmodule

// File: rtl/manch_tx.sv
module manch_tx
  import manch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_tick_i,
  input  logic              pol_i,
  input  logic [1:0]        pat_sel_i,
  input  logic [LEN_W-1:0]  pre_len_i,
  input  logic              idle_lvl_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              line_o,
  output logic              busy_o
);
  localparam int MAX_BITS = (2 ** LEN_W) - 1 + 1 + DATA_W;
  localparam int CNT_W    = $clog2(2 * MAX_BITS + 1);
  localparam int IDX_W    = CNT_W - 1;

  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              line_q;
  logic [CNT_W-1:0]  total_halves;
  logic              cur_bit;
  logic              cur_lvl;

  assign total_halves = CNT_W'((CNT_W'(cfg_q.len) + CNT_W'(DATA_W + 1)) << 1);

  manch_bit_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bit_sel (
    .idx_i  (cnt_q[CNT_W-1:1]),
    .cfg_i  (cfg_q),
    .data_i (data_q),
    .bit_o  (cur_bit)
  );

  manch_enc u_enc (
    .bit_i    (cur_bit),
    .pol_i    (cfg_q.pol),
    .second_i (cnt_q[0]),
    .lvl_o    (cur_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      line_q <= 1'b1;
      cnt_q  <= '0;
      data_q <= '0;
      cfg_q  <= '{pol: 1'b1, pat: PAT_ONES, len: LEN_W'(4)};
    end else if (!busy_q) begin
      line_q <= idle_lvl_i;
      if (valid_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        data_q <= data_i;
        cfg_q  <= '{pol: pol_i, pat: pat_e'(pat_sel_i), len: pre_len_i};
      end
    end else if (half_tick_i) begin
      if (cnt_q == total_halves) begin
        busy_q <= 1'b0;
        line_q <= idle_lvl_i;
      end else begin
        line_q <= cur_lvl;
        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = ~busy_q;
  assign line_o  = line_q;
endmodule

// File: rtl/manch_tx_chk.sv
module manch_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic half_tick_i,
  input logic idle_lvl_i,
  input logic valid_i,
  input logic ready_o,
  input logic line_o,
  input logic busy_o
);
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> busy_o);

  p_no_ready_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ready_o);

  p_idle_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> line_o == $past(idle_lvl_i));

  p_hold_between_ticks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !half_tick_i |=> $stable(line_o) && busy_o);

  p_end_on_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(half_tick_i));
endmodule

bind manch_tx manch_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .half_tick_i (half_tick_i),
  .idle_lvl_i  (idle_lvl_i),
  .valid_i     (valid_i),
  .ready_o     (ready_o),
  .line_o      (line_o),
  .busy_o      (busy_o)
);

// File: tb/manch_tx_test.sv
module manch_tx_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       half_tick_i = 1'b0;
  logic       pol_i = 1'b0;
  logic [1:0] pat_sel_i = 2'd0;
  logic [3:0] pre_len_i = 4'd0;
  logic       idle_lvl_i = 1'b1;
  logic [7:0] data_i = 8'h00;
  logic       valid_i = 1'b0;
  logic       ready_o, line_o, busy_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk_i = ~clk_i;

  manch_tx uut (
    .clk_i, .rst_ni, .half_tick_i, .pol_i, .pat_sel_i, .pre_len_i,
    .idle_lvl_i, .data_i, .valid_i, .ready_o, .line_o, .busy_o
  );

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_bit(int b, int len, int sel, logic [7:0] d);
    if (b < len) begin
      case (sel)
        0: return 1'b1;
        1: return 1'b0;
        2: return bit'(b % 2);
        default: return bit'(1 - (b % 2));
      endcase
    end else if (b == len) return 1'b0;
    return d[b - len - 1];
  endfunction

  task automatic t_reset();
    @(negedge clk_i);
    check(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
    check(ready_o == 1'b1, "R1 ready in reset", ready_o, 1);
    check(line_o == 1'b1, "R1 line in reset", line_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_idle();
    idle_lvl_i = 1'b0;
    @(negedge clk_i);
    check(line_o == 1'b0, "R3 idle low", line_o, 0);
    for (int i = 0; i < 3; i++) begin
      half_tick_i = 1'b1;
      @(negedge clk_i);
      half_tick_i = 1'b0;
      check(line_o == 1'b0 && busy_o == 1'b0, "R3 tick while idle", line_o, 0);
    end
    idle_lvl_i = 1'b1;
    @(negedge clk_i);
    check(line_o == 1'b1, "R3 idle high", line_o, 1);
  endtask

  // disturb: change config and offer another byte mid-frame (R10, R11)
  task automatic t_frame(input logic [7:0] d, input bit pol, input int sel, input int len,
                         input bit idl, input bit disturb, input string tag);
    int nh;
    bit b, lvl;
    nh = 2 * (len + 9);
    pol_i = pol; pat_sel_i = 2'(sel); pre_len_i = 4'(len); idle_lvl_i = idl;
    data_i = d; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(busy_o == 1'b1 && ready_o == 1'b0, {tag, " R2 accept"}, busy_o, 1);
    check(line_o == idl, {tag, " R3 line before first tick"}, line_o, idl);
    if (disturb) begin
      pol_i = ~pol; pat_sel_i = 2'(sel + 1); pre_len_i = 4'(len + 3);
    end
    for (int k = 0; k < nh; k++) begin
      half_tick_i = 1'b1;
      @(negedge clk_i);
      half_tick_i = 1'b0;
      b = exp_bit(k / 2, len, sel, d);
      lvl = b ^ pol ^ bit'(k % 2);
      check(line_o == lvl, $sformatf("%s R4/R6/R7/R8/R10 half %0d", tag, k), line_o, lvl);
      if (disturb && k == 5) begin
        data_i = ~d; valid_i = 1'b1;
        check(ready_o == 1'b0, {tag, " R11 ready low in frame"}, ready_o, 0);
      end
      @(negedge clk_i);
      valid_i = 1'b0;
      check(line_o == lvl && busy_o == 1'b1, $sformatf("%s R5 hold half %0d", tag, k), line_o, lvl);
    end
    half_tick_i = 1'b1;
    @(negedge clk_i);
    half_tick_i = 1'b0;
    check(busy_o == 1'b0, {tag, " R9 busy clears"}, busy_o, 0);
    check(line_o == idl, {tag, " R9 line back to idle"}, line_o, idl);
    for (int i = 0; i < 4; i++) @(negedge clk_i);
    check(busy_o == 1'b0 && line_o == idl, {tag, " R11 no extra frame"}, busy_o, 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_frame(8'hA5, 1'b0, 0, 4, 1'b1, 1'b0, "ones_pol0");
    t_frame(8'h3C, 1'b1, 2, 3, 1'b0, 1'b0, "zo_pol1");
    t_frame(8'hC1, 1'b0, 3, 5, 1'b1, 1'b0, "oz_pol0");
    t_frame(8'h7E, 1'b1, 1, 2, 1'b1, 1'b0, "zeros_pol1");
    t_frame(8'h01, 1'b0, 0, 0, 1'b0, 1'b0, "no_preamble");
    t_frame(8'h96, 1'b1, 2, 15, 1'b1, 1'b0, "max_preamble");
    t_frame(8'h5A, 1'b0, 1, 6, 1'b1, 1'b1, "disturbed");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule